// File: doc/BRIEF.md
# LCD Frame-Sync Timing Generator

This block drives a parallel RGB LCD panel. From the system clock it derives a pixel clock through a programmable divider. Counting pixel clocks, it produces an active-high horizontal sync, an active-high vertical sync and a data-enable window. Inside that window it takes one 32-bit word per pixel from a ready/valid input stream. It clamps each colour component to programmable limits and presents the result on a 24-bit pixel bus, either as an 8-8-8 pixel or as a packed 6-6-6 pixel.

Every timing quantity arrives on a configuration input:
- the line length and the horizontal sync width, in pixel clocks;
- the vertical sync width and the vertical sync period, also in pixel clocks;
- a horizontal delay and an active sample count, both counted from the start of each line;
- a vertical delay and an active line count, both counted from the start of each frame.

Outputs change only on the falling pixel-clock edge, so the panel can sample on the rising edge. The horizontal and vertical counters run on a shared pixel tick. The active window is the intersection of the horizontal and vertical windows. A typical panel setting is a 525-clock line with 480 active samples starting 43 clocks after sync, and a 286-line frame with 272 active lines.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `en` is high, `pclk` has a period of exactly 2*(`cfg_div`+1) system clocks, with equal high and low halves. The first half-period after enabling is low.
- R2: `hsync`, `vsync`, `de` and `pix_data` change only in the system cycle in which `pclk` falls.
- R3: Number the pixel clocks since enable from 0. At position p, `hsync` is 1 exactly when (p mod `cfg_line_len`) < `cfg_hs_width`.
- R4: At position p, `vsync` is 1 exactly when (p mod `cfg_vs_period`) < `cfg_vs_width`. Both quantities are in pixel clocks.
- R5: Let h = p mod `cfg_line_len` and n = (p mod `cfg_vs_period`) div `cfg_line_len`, where the period is a multiple of the line length. `de` is 1 exactly when `cfg_h_delay` <= h < `cfg_h_delay`+`cfg_h_active` and `cfg_v_delay` <= n < `cfg_v_delay`+`cfg_v_active`.
- R6: `s_ready` is 1 only in the system cycle that ends with the falling `pclk` edge of an active position. At most one word is taken per active pixel, and none outside the window.
- R7: `pix_data` is zero at every position outside the window. It is also zero at an active position whose word was not valid when `s_ready` was high.
- R8: Components are clamped before formatting, assuming each lower limit is no greater than its upper limit. Red (word bits 23:16) and blue (bits 7:0) are limited to [`cfg_clip`[23:16], `cfg_clip`[31:24]]. Green (bits 15:8) is limited to [`cfg_clip`[7:0], `cfg_clip`[15:8]].
- R9: With `cfg_rgb666` = 0, `pix_data` = {R, G, B} of the clamped components, with R in bits 23:16.
- R10: With `cfg_rgb666` = 1, `pix_data` = {6'b0, R[7:2], G[7:2], B[7:2]}, which keeps the upper six bits of each clamped component.
- R11: While `en` is low, `pclk`, `hsync`, `vsync`, `de`, `pix_data` and `s_ready` are all zero after one cycle, and the counters return to position 0.
- R12: After synchronous reset (`rst` high), all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the generator idle at position 0 |
| cfg_div | input | 16 | Pixel clock divider value |
| cfg_line_len | input | 16 | Pixel clocks per line |
| cfg_hs_width | input | 16 | Horizontal sync width in pixel clocks |
| cfg_h_delay | input | 16 | First active sample position in a line |
| cfg_h_active | input | 16 | Active samples per line |
| cfg_vs_width | input | 32 | Vertical sync width in pixel clocks |
| cfg_vs_period | input | 32 | Vertical sync period in pixel clocks |
| cfg_v_delay | input | 16 | First active line in a frame |
| cfg_v_active | input | 16 | Active lines per frame |
| cfg_rgb666 | input | 1 | 1 selects packed 6-6-6 output, 0 selects 8-8-8 |
| cfg_clip | input | 32 | Component clamp limits |
| s_data | input | 32 | Input pixel word, one pixel in bits 23:0 |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word taken at the next clock edge |
| pclk | output | 1 | Pixel clock |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-data window |
| pix_data | output | 24 | Output pixel |

## Verification
Several properties are checked on every cycle:
- the sync, window and pixel outputs move only with a falling pixel clock;
- a taken word always lands in an active pixel;
- the pixel bus is zero outside the window;
- packed 6-6-6 output leaves its upper bits clear;
- clamped components stay within their limits;
- disabling the block empties every output.

Three things can only be shown by the bench's scenarios, which compare against a position-based model over whole frames:
- the exact sync widths and periods;
- the placement of the window relative to each sync;
- the pixel-clock period for each divider value.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int COMP_W  = 8;
  localparam int NCOMP   = 3;
  localparam int PIX_W   = COMP_W * NCOMP;
  localparam int TRUNC_W = COMP_W - 2;
  localparam int CLIP_W  = 32;

  typedef struct packed {
    logic [COMP_W-1:0] hi;
    logic [COMP_W-1:0] lo;
  } comp_lim_t;

  function automatic logic [COMP_W-1:0] clamp_comp(
      input logic [COMP_W-1:0] v, input comp_lim_t lim);
    if (v > lim.hi) return lim.hi;
    if (v < lim.lo) return lim.lo;
    return v;
  endfunction
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             pclk,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = 1;
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div);
  // tick marks the cycle whose closing edge drops pclk
  assign tick = en && wrap && pclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      pclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      pclk <= ~pclk;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/lcd_frame_cnt.sv
module lcd_frame_cnt #(
  parameter int H_W = 16,
  parameter int V_W = 16,
  parameter int F_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           tick,
  input  logic [H_W-1:0] line_len,
  input  logic [H_W-1:0] hs_width,
  input  logic [H_W-1:0] h_delay,
  input  logic [H_W-1:0] h_active,
  input  logic [F_W-1:0] vs_width,
  input  logic [F_W-1:0] vs_period,
  input  logic [V_W-1:0] v_delay,
  input  logic [V_W-1:0] v_active,
  output logic           hs_now,
  output logic           vs_now,
  output logic           act_now
);
  localparam logic [H_W-1:0] H_ONE = 1;
  localparam logic [V_W-1:0] V_ONE = 1;
  localparam logic [F_W-1:0] F_ONE = 1;

  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vline;
  logic [F_W-1:0] fcnt;
  logic           h_wrap, f_wrap;
  logic [H_W:0]   h_end;
  logic [V_W:0]   v_end;
  logic           h_in, v_in;

  assign h_wrap = (hcnt >= line_len - H_ONE);
  assign f_wrap = (fcnt >= vs_period - F_ONE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt  <= '0;
      fcnt  <= '0;
      vline <= '0;
    end else if (tick) begin
      hcnt <= h_wrap ? '0 : hcnt + H_ONE;
      fcnt <= f_wrap ? '0 : fcnt + F_ONE;
      if (f_wrap)      vline <= '0;
      else if (h_wrap) vline <= vline + V_ONE;
    end
  end

  assign h_end   = {1'b0, h_delay} + {1'b0, h_active};
  assign v_end   = {1'b0, v_delay} + {1'b0, v_active};
  assign h_in    = (hcnt >= h_delay) && ({1'b0, hcnt} < h_end);
  assign v_in    = (vline >= v_delay) && ({1'b0, vline} < v_end);
  assign hs_now  = (hcnt < hs_width);
  assign vs_now  = (fcnt < vs_width);
  assign act_now = h_in && v_in;
endmodule

// File: rtl/lcd_pix_fmt.sv
module lcd_pix_fmt
  import lcd_sync_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CLIP_W-1:0] clip,
  input  logic              mode666,
  output logic [PIX_W-1:0]  pix
);
  logic [PIX_W-1:0]         p888;
  logic [NCOMP*TRUNC_W-1:0] p666;
  logic                     unused_hi;

  assign unused_hi = ^word[WORD_W-1:PIX_W];

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    comp_lim_t         lim;
    logic [COMP_W-1:0] c;
    // component 1 (green) uses the low clip pair, others the high pair
    if (i == 1) begin : g_mid
      assign lim = comp_lim_t'(clip[2*COMP_W-1:0]);
    end else begin : g_side
      assign lim = comp_lim_t'(clip[CLIP_W-1:CLIP_W-2*COMP_W]);
    end
    assign c = clamp_comp(word[i*COMP_W +: COMP_W], lim);
    assign p888[i*COMP_W +: COMP_W]   = c;
    assign p666[i*TRUNC_W +: TRUNC_W] = c[COMP_W-1 -: TRUNC_W];
  end

  assign pix = mode666 ? {{(PIX_W-NCOMP*TRUNC_W){1'b0}}, p666} : p888;
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int H_W    = 16,
  parameter int V_W    = 16,
  parameter int F_W    = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [H_W-1:0]    cfg_line_len,
  input  logic [H_W-1:0]    cfg_hs_width,
  input  logic [H_W-1:0]    cfg_h_delay,
  input  logic [H_W-1:0]    cfg_h_active,
  input  logic [F_W-1:0]    cfg_vs_width,
  input  logic [F_W-1:0]    cfg_vs_period,
  input  logic [V_W-1:0]    cfg_v_delay,
  input  logic [V_W-1:0]    cfg_v_active,
  input  logic              cfg_rgb666,
  input  logic [CLIP_W-1:0] cfg_clip,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              pclk,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_data
);
  logic             tick;
  logic             hs_now, vs_now, act_now;
  logic [PIX_W-1:0] fmt_pix;

  lcd_pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(en), .div(cfg_div), .pclk(pclk), .tick(tick)
  );

  lcd_frame_cnt #(.H_W(H_W), .V_W(V_W), .F_W(F_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .line_len(cfg_line_len), .hs_width(cfg_hs_width),
    .h_delay(cfg_h_delay), .h_active(cfg_h_active),
    .vs_width(cfg_vs_width), .vs_period(cfg_vs_period),
    .v_delay(cfg_v_delay), .v_active(cfg_v_active),
    .hs_now(hs_now), .vs_now(vs_now), .act_now(act_now)
  );

  lcd_pix_fmt #(.WORD_W(WORD_W)) u_fmt (
    .word(s_data), .clip(cfg_clip), .mode666(cfg_rgb666), .pix(fmt_pix)
  );

  // a word is taken only on the edge that opens an active pixel
  assign s_ready = tick && act_now;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      de       <= 1'b0;
      pix_data <= '0;
    end else if (tick) begin
      hsync    <= hs_now;
      vsync    <= vs_now;
      de       <= act_now;
      pix_data <= (act_now && s_valid) ? fmt_pix : '0;
    end
  end
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int PIX_W  = 24,
  parameter int CLIP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              cfg_rgb666,
  input logic [CLIP_W-1:0] cfg_clip,
  input logic              s_valid,
  input logic              s_ready,
  input logic              pclk,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [PIX_W-1:0]  pix_data
);
  a_r2_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable({hsync, vsync, de, pix_data})) |-> ($past(pclk) && !pclk));

  a_r6_take_in_window: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> (de && !pclk && $past(pclk)));

  a_r7_zero_outside: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_data == '0));

  a_r8_green_limits: assert property (@(posedge clk) disable iff (rst)
    ($past(s_ready) && $past(s_valid) && !$past(cfg_rgb666) &&
     ($past(cfg_clip[7:0]) <= $past(cfg_clip[15:8])))
    |-> (pix_data[15:8] <= $past(cfg_clip[15:8]) && pix_data[15:8] >= $past(cfg_clip[7:0])));

  a_r8_red_limits: assert property (@(posedge clk) disable iff (rst)
    ($past(s_ready) && $past(s_valid) && !$past(cfg_rgb666) &&
     ($past(cfg_clip[23:16]) <= $past(cfg_clip[31:24])))
    |-> (pix_data[23:16] <= $past(cfg_clip[31:24]) && pix_data[23:16] >= $past(cfg_clip[23:16])));

  a_r10_packed_top_clear: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(pclk) && !pclk && $past(cfg_rgb666)) |-> (pix_data[PIX_W-1:18] == '0));

  a_r11_idle_outputs: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pclk && !hsync && !vsync && !de && pix_data == '0));

  a_r11_no_take_idle: assert property (@(posedge clk) disable iff (rst)
    !en |-> !s_ready);
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.PIX_W(24), .CLIP_W(32)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cfg_rgb666(cfg_rgb666), .cfg_clip(cfg_clip),
  .s_valid(s_valid), .s_ready(s_ready), .pclk(pclk), .hsync(hsync),
  .vsync(vsync), .de(de), .pix_data(pix_data)
);

// File: tb/lcd_sync_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, en, cfg_rgb666, s_valid, s_ready, pclk, hsync, vsync, de;
  logic [15:0] cfg_div, cfg_line_len, cfg_hs_width, cfg_h_delay, cfg_h_active;
  logic [15:0] cfg_v_delay, cfg_v_active;
  logic [31:0] cfg_vs_width, cfg_vs_period, cfg_clip, s_data;
  logic [23:0] pix_data;

  lcd_sync_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_div(cfg_div), .cfg_line_len(cfg_line_len),
    .cfg_hs_width(cfg_hs_width), .cfg_h_delay(cfg_h_delay), .cfg_h_active(cfg_h_active),
    .cfg_vs_width(cfg_vs_width), .cfg_vs_period(cfg_vs_period), .cfg_v_delay(cfg_v_delay),
    .cfg_v_active(cfg_v_active), .cfg_rgb666(cfg_rgb666), .cfg_clip(cfg_clip),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .pclk(pclk), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_data(pix_data)
  );

  int n_chk = 0, n_fail = 0;
  int L, HS, HD, HC, F, P, VSW, VD, VC, DIV;
  bit M666;
  logic [31:0] CLIP;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_h(int p); return (p % L) < HS; endfunction
  function automatic bit exp_v(int p); return (p % P) < VSW; endfunction
  function automatic bit exp_act(int p);
    int h, n;
    h = p % L;
    n = (p % P) / L;
    return (h >= HD) && (h < HD + HC) && (n >= VD) && (n < VD + VC);
  endfunction

  function automatic logic [23:0] fmt(logic [31:0] w);
    logic [7:0] c [3];
    logic [7:0] hi, lo;
    for (int i = 0; i < 3; i++) begin
      hi = (i == 1) ? CLIP[15:8] : CLIP[31:24];
      lo = (i == 1) ? CLIP[7:0]  : CLIP[23:16];
      c[i] = w[i*8 +: 8];
      if (c[i] > hi) c[i] = hi;
      else if (c[i] < lo) c[i] = lo;
    end
    if (M666) return {6'b0, c[2][7:2], c[1][7:2], c[0][7:2]};
    return {c[2], c[1], c[0]};
  endfunction

  task automatic apply_cfg();
    cfg_div = 16'(DIV); cfg_line_len = 16'(L); cfg_hs_width = 16'(HS);
    cfg_h_delay = 16'(HD); cfg_h_active = 16'(HC); cfg_vs_width = 32'(VSW);
    cfg_vs_period = 32'(P); cfg_v_delay = 16'(VD); cfg_v_active = 16'(VC);
    cfg_rgb666 = M666; cfg_clip = CLIP;
  endtask

  // R11: after dropping en, every output sits at zero
  task automatic idle_check(int n);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({pclk, hsync, vsync, de, s_ready} == 5'b0 && pix_data == 24'h0, "R11 idle outputs",
          {pix_data, 3'b0, pclk, hsync, vsync, de, s_ready}, 32'h0);
    end
  endtask

  task automatic run_ticks(int n);
    int k = 0, since = 0, p;
    bit pp = 0, lh = 0, lv = 0, ld = 0, pr = 0, pv = 0, ea;
    logic [23:0] lp = '0, ep;
    logic [31:0] pd = '0;
    en = 1'b1;
    while (k < n) begin
      @(negedge clk);
      since++;
      if (pp && !pclk) begin
        p = k;
        k++;
        if (k >= 2) chk(since == 2 * (DIV + 1), "R1 pclk period", since, 2 * (DIV + 1));
        since = 0;
        ea = exp_act(p);
        chk(hsync == exp_h(p), "R3 hsync", hsync, exp_h(p));
        chk(vsync == exp_v(p), "R4 vsync", vsync, exp_v(p));
        chk(de == ea, "R5 window", de, ea);
        chk(pr == ea, "R6 ready", pr, ea);
        ep = (pr && pv) ? fmt(pd) : 24'h0;
        if (!ea || !pv) chk(pix_data == ep, "R7 zero pixel", pix_data, ep);
        else chk(pix_data == ep, M666 ? "R10/R8 packed pixel" : "R9/R8 pixel", pix_data, ep);
      end else begin
        chk(hsync == lh && vsync == lv && de == ld && pix_data == lp, "R2 hold between falls",
            {pix_data, 5'b0, hsync, vsync, de}, {lp, 5'b0, lh, lv, ld});
      end
      pp = pclk; lh = hsync; lv = vsync; ld = de; lp = pix_data;
      s_data = $urandom;
      s_valid = ($urandom % 8) != 0;
      pr = s_ready; pv = s_valid; pd = s_data;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'h1cd5));
    L = 20; HS = 3; HD = 5; HC = 10; F = 8; P = 160; VSW = 40; VD = 2; VC = 4; DIV = 0;
    M666 = 0; CLIP = 32'hFF00FF00;
    apply_cfg();
    s_data = '0; s_valid = 0; en = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset clears every output
    chk({pclk, hsync, vsync, de, s_ready} == 5'b0 && pix_data == 24'h0, "R12 reset state",
        {pix_data, 3'b0, pclk, hsync, vsync, de, s_ready}, 32'h0);
    en = 1'b0; rst = 1'b0;
    @(negedge clk);

    // pass-through limits, 8-8-8 output
    run_ticks(2 * P + 3);
    idle_check(3);

    // window ends at line end, first line active, tight limits
    L = 20; HS = 4; HD = 6; HC = 14; VD = 0; VC = 8; DIV = 2; CLIP = 32'hC030A050;
    apply_cfg();
    run_ticks(2 * P + 3);
    idle_check(3);

    // packed output, disabled mid-frame then restarted
    L = 16; HS = 1; HD = 2; HC = 12; F = 6; P = 96; VSW = 32; VD = 1; VC = 3; DIV = 1;
    M666 = 1; CLIP = 32'hE020F010;
    apply_cfg();
    run_ticks(50);
    idle_check(4);
    run_ticks(2 * P + 3);
    idle_check(2);

    // random geometries
    for (int r = 0; r < 4; r++) begin
      L = $urandom_range(30, 12); HS = $urandom_range(L - 1, 1);
      HD = $urandom_range(L / 2, 0); HC = $urandom_range(L - HD, 1);
      F = $urandom_range(8, 4); P = L * F; VSW = $urandom_range(P - 1, 1);
      VD = $urandom_range(F - 1, 0); VC = $urandom_range(F - VD, 1);
      DIV = $urandom_range(3, 0); M666 = $urandom_range(1, 0);
      CLIP = {8'($urandom_range(255, 128)), 8'($urandom_range(127, 0)),
              8'($urandom_range(255, 128)), 8'($urandom_range(127, 0))};
      apply_cfg();
      run_ticks(2 * P + 3);
      idle_check(2);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end
endmodule